// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller

This block is the clocked front end of a pipelined burst static RAM. On each rising clock edge it registers the address and control inputs. It decodes three chip selects and two address strobes into one of four cycle kinds: start a burst, step to the next address, hold the current address, or deselect. It also turns a global write, a byte-write enable and two byte strobes into per-byte write enables. These drive a small internal memory of 18-bit words, each split into two 9-bit bytes.

A burst can start from either strobe. The processor strobe only ever reads and is ignored while the primary select is high. The controller strobe can read or write. Within a burst, the low address bits come from a two-bit burst counter that steps in either linear or interleaved order; the upper address bits stay in a register for the whole burst. Read data appears one clock after the access, flagged by a valid output. An asynchronous output enable and a sleep input gate whether that data is driven. After sleep is released, the block needs two clocks to wake up.

Top module: `sbsram_ctrl`

## Requirements
- R1: After synchronous reset, `rvalid` and `out_en` are low.
- R2: When `adsp_n` is low and all selects are active (`cs1_n` low, `cs2` high, `cs2_n` low), a read burst starts at `addr_i`. After that edge `rvalid` is high and, with `oe_n` low, `rdata` holds the stored word.
- R3: While `cs1_n` is high, `adsp_n` has no effect. With `adsc_n` high, the edge acts as a step or hold of the running burst.
- R4: A strobe that is active while any select is inactive is a deselect. It clears `rvalid` at that edge and ends the burst, so later step or hold cycles neither read nor write until a new burst starts.
- R5: When `adsc_n` is low, `adsp_n` is not effective and all selects are active, a burst starts at `addr_i`. The edge is a write if the write decode asks for one; otherwise it is a read.
- R6: `gw_n` low writes both bytes, whatever `bwe_n` and `bws_n` are.
- R7: With `gw_n` high and `bwe_n` low, `bws_n[0]` low writes byte a (`wdata[8:0]`) and `bws_n[1]` low writes byte b (`wdata[17:9]`). Write data is taken on the same edge as the write decode.
- R8: An access is a read when `gw_n` and `bwe_n` are both high, or when `bwe_n` is low and both `bws_n` bits are high.
- R9: With `ilv_mode` low, `adsp_n`/`adsc_n` high and `adv_n` low, the burst steps in linear order: the low two address bits go start, start+1, start+2, start+3 (mod 4), then wrap back to start. The upper bits stay fixed.
- R10: With `ilv_mode` high, the low two address bits go start XOR 0, 1, 2, 3.
- R11: With both strobes high and `adv_n` high, the access repeats the current address, for reads and for writes.
- R12: `out_en` is high only while `rvalid` is high, `oe_n` is low and `sleep` is low; it follows `oe_n` and `sleep` without waiting for a clock. While `out_en` is low, `rdata` is zero.
- R13: While `sleep` is high, and on the first two edges after it falls, all synchronous inputs are ignored and `rvalid` is low. Memory and burst position are kept, and the third edge acts normally.
- R14: A burst started by `adsp_n` is a read even when a write is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Power-down request, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| cs1_n | input | 1 | Primary select, active low |
| cs2 | input | 1 | Select, active high |
| cs2_n | input | 1 | Select, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bws_n | input | 2 | Byte strobes, bit 0 byte a, bit 1 byte b, active low |
| addr_i | input | ADDR_W | External word address |
| wdata | input | 18 | Write data, byte b in [17:9], byte a in [8:0] |
| rdata | output | 18 | Read data, zero when not driven |
| rvalid | output | 1 | Read data valid, one cycle after the access |
| out_en | output | 1 | Output driven; low models high impedance |

## Verification
A wrong burst counter or a lost upper-address register shows up on the very next edge: `rdata` returns another address's word, because each test address holds a distinct pattern. A burst-active flag that survives a deselect shows up in two ways. `rvalid` rises on a step cycle that should be idle, and a stray write is found by a later readback. A wrong wake-up count shows up as early `rvalid`, or as a burst that has advanced too far when it resumes after sleep.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  // kind of synchronous cycle decoded from selects and strobes
  typedef enum logic [1:0] {
    CY_DSEL  = 2'd0,
    CY_START = 2'd1,
    CY_NEXT  = 2'd2,
    CY_HOLD  = 2'd3
  } cycle_e;

  // clock edges ignored after sleep is released
  localparam int WAKE_CYCLES = 2;
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int NBYTES = 2
) (
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs2_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [NBYTES-1:0] bws_n,
  output cycle_e            cyc,
  output logic [NBYTES-1:0] wr_be
);
  logic              sel_all;
  logic              p_strobe;
  logic [NBYTES-1:0] req_be;

  always_comb begin
    sel_all  = !cs1_n && cs2 && !cs2_n;
    // processor strobe is only seen while the primary select is low
    p_strobe = !adsp_n && !cs1_n;
    if (!gw_n)       req_be = '1;
    else if (!bwe_n) req_be = ~bws_n;
    else             req_be = '0;
    wr_be = req_be;
    if (p_strobe) begin
      cyc   = sel_all ? CY_START : CY_DSEL;
      wr_be = '0;                       // processor start is always a read
    end else if (!adsc_n) begin
      cyc = sel_all ? CY_START : CY_DSEL;
    end else begin
      cyc = adv_n ? CY_HOLD : CY_NEXT;
    end
  end
endmodule

// File: rtl/sbsram_burst_ctr.sv
module sbsram_burst_ctr #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic          ilv,
  input  logic [BW-1:0] ld_lo,
  output logic [BW-1:0] cur_lo,
  output logic [BW-1:0] nxt_lo
);
  logic [BW-1:0] base_q;
  logic [BW-1:0] cnt_q;
  logic [BW-1:0] cnt_nx;

  assign cnt_nx = cnt_q + 1'b1;
  assign cur_lo = ilv ? (base_q ^ cnt_q)  : (base_q + cnt_q);
  assign nxt_lo = ilv ? (base_q ^ cnt_nx) : (base_q + cnt_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= ld_lo;
      cnt_q  <= '0;
    end else if (adv) begin
      cnt_q  <= cnt_nx;
    end
  end
endmodule

// File: rtl/sbsram_mem.sv
module sbsram_mem #(
  parameter int AW     = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2,
  localparam int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic [NBYTES-1:0] we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] ram [DEPTH];
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (we[b]) ram[addr] <= wdata[b*BYTE_W +: BYTE_W];
      if (re)    q <= ram[addr];
    end
    assign rdata[b*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BYTE_W  = 9,
  parameter int NBYTES  = 2,
  parameter int BURST_W = 2,
  localparam int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              oe_n,
  input  logic              ilv_mode,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs2_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [NBYTES-1:0] bws_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              out_en
);
  localparam int HI_W = ADDR_W - BURST_W;
  localparam int WK_W = $clog2(WAKE_CYCLES + 1);

  cycle_e              cyc;
  logic [NBYTES-1:0]   dec_be;
  logic [NBYTES-1:0]   mem_we;
  logic                mem_re;
  logic                awake;
  logic                go;
  logic                burst_act;
  logic                rd_q;
  logic [WK_W-1:0]     wake_q;
  logic [HI_W-1:0]     hi_q;
  logic [HI_W-1:0]     acc_hi;
  logic [BURST_W-1:0]  cur_lo;
  logic [BURST_W-1:0]  nxt_lo;
  logic [BURST_W-1:0]  acc_lo;
  logic [DATA_W-1:0]   mem_q;

  sbsram_decode #(.NBYTES(NBYTES)) u_dec (
    .cs1_n (cs1_n),  .cs2   (cs2),    .cs2_n (cs2_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n (adv_n),
    .gw_n  (gw_n),   .bwe_n (bwe_n),  .bws_n (bws_n),
    .cyc   (cyc),    .wr_be (dec_be)
  );

  sbsram_burst_ctr #(.BW(BURST_W)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .load  (awake && cyc == CY_START),
    .adv   (awake && cyc == CY_NEXT && burst_act),
    .ilv   (ilv_mode),
    .ld_lo (addr_i[BURST_W-1:0]),
    .cur_lo(cur_lo),
    .nxt_lo(nxt_lo)
  );

  always_comb begin
    awake  = !sleep && (wake_q == '0);
    go     = awake && ((cyc == CY_START) ||
                       (burst_act && (cyc == CY_NEXT || cyc == CY_HOLD)));
    acc_hi = (cyc == CY_START) ? addr_i[ADDR_W-1:BURST_W] : hi_q;
    case (cyc)
      CY_START: acc_lo = addr_i[BURST_W-1:0];
      CY_NEXT:  acc_lo = nxt_lo;
      default:  acc_lo = cur_lo;
    endcase
    mem_we = go ? dec_be : '0;
    mem_re = go && (dec_be == '0);
  end

  sbsram_mem #(.AW(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .re   (mem_re),
    .addr ({acc_hi, acc_lo}),
    .wdata(wdata),
    .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_q    <= '0;
      burst_act <= 1'b0;
      rd_q      <= 1'b0;
      hi_q      <= '0;
    end else begin
      if (sleep)            wake_q <= WK_W'(WAKE_CYCLES);
      else if (wake_q != 0) wake_q <= wake_q - 1'b1;
      rd_q <= mem_re;
      if (awake && cyc == CY_START) begin
        burst_act <= 1'b1;
        hi_q      <= addr_i[ADDR_W-1:BURST_W];
      end else if (awake && cyc == CY_DSEL) begin
        burst_act <= 1'b0;
      end
    end
  end

  assign rvalid = rd_q;
  assign out_en = rd_q && !oe_n && !sleep;
  assign rdata  = out_en ? mem_q : '0;
endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep,
  input logic              oe_n,
  input logic              cs1_n,
  input logic              cs2,
  input logic              cs2_n,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              awake,
  input logic              rvalid,
  input logic              out_en,
  input logic [DATA_W-1:0] rdata
);
  // R2
  start_read_chk: assert property (@(posedge clk) disable iff (rst)
    (awake && !adsp_n && !cs1_n && cs2 && !cs2_n) |=> rvalid);

  // R4
  dsel_chk: assert property (@(posedge clk) disable iff (rst)
    (awake && ((!adsp_n && !cs1_n) || !adsc_n) && !(!cs1_n && cs2 && !cs2_n))
      |=> !rvalid);

  // R13
  sleep_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !rvalid);

  // R13
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep) |=> !rvalid);

  // R12
  oe_chk: assert property (@(posedge clk) disable iff (rst)
    out_en |-> (rvalid && !oe_n));

  // R12
  hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> (rdata == '0));
endmodule

bind sbsram_ctrl sbsram_chk #(.DATA_W(DATA_W)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .sleep (sleep),
  .oe_n  (oe_n),
  .cs1_n (cs1_n),
  .cs2   (cs2),
  .cs2_n (cs2_n),
  .adsp_n(adsp_n),
  .adsc_n(adsc_n),
  .awake (awake),
  .rvalid(rvalid),
  .out_en(out_en),
  .rdata (rdata)
);

// File: tb/sbsram_ctrl_tb_top.sv
module sbsram_ctrl_tb_top;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep = 1'b0, oe_n = 1'b0, ilv_mode = 1'b0;
  logic cs1_n = 1'b1, cs2 = 1'b1, cs2_n = 1'b0;
  logic adsp_n = 1'b1, adsc_n = 1'b0, adv_n = 1'b1;
  logic gw_n = 1'b1, bwe_n = 1'b1;
  logic [1:0]    bws_n = 2'b11;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid, out_en;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [64];

  always #2 clk = ~clk;

  sbsram_ctrl dut_i (
    .clk(clk), .rst(rst), .sleep(sleep), .oe_n(oe_n), .ilv_mode(ilv_mode),
    .cs1_n(cs1_n), .cs2(cs2), .cs2_n(cs2_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bws_n(bws_n), .addr_i(addr_i),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .out_en(out_en)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // deselect cycle: controller strobe with primary select high
  task automatic nop_in;
    cs1_n = 1; cs2 = 1; cs2_n = 0; adsp_n = 1; adsc_n = 0; adv_n = 1;
    gw_n = 1; bwe_n = 1; bws_n = 2'b11;
  endtask

  task automatic sel_in;
    cs1_n = 0; cs2 = 1; cs2_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bws_n = 2'b11;
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 2731 + 517) ^ (a << 11));
  endfunction

  task automatic wr_ctl(input int a, input logic [DW-1:0] d, input logic g,
                        input logic be, input logic [1:0] bs);
    sel_in; adsc_n = 0; addr_i = AW'(a); wdata = d; gw_n = g; bwe_n = be; bws_n = bs;
    tick;
    if (!g) model[a] = d;
    else if (!be) begin
      if (!bs[0]) model[a][8:0]  = d[8:0];
      if (!bs[1]) model[a][17:9] = d[17:9];
    end
    nop_in; tick;
  endtask

  task automatic rd_p(input int a, input string req);
    sel_in; adsp_n = 0; addr_i = AW'(a);
    tick;
    chk(req, {17'd0, rvalid}, 18'd1);
    chk(req, rdata, model[a]);
  endtask

  task automatic step(input int a, input string req);
    sel_in; adv_n = 0;
    tick;
    chk(req, {17'd0, rvalid}, 18'd1);
    chk(req, rdata, model[a]);
  endtask

  task automatic t_reset;
    chk("R1 rvalid", {17'd0, rvalid}, 18'd0);
    chk("R1 out_en", {17'd0, out_en}, 18'd0);
  endtask

  task automatic t_fill;
    for (int a = 0; a < 32; a++) wr_ctl(a, pat(a), 1'b0, 1'b1, 2'b11);
    rd_p(7, "R5 controller write then read");
    nop_in; tick;
  endtask

  task automatic t_linear;
    ilv_mode = 0;
    rd_p(9, "R9 first");
    step(10, "R9 second");
    step(11, "R9 third");
    step(8, "R9 fourth");
    step(9, "R9 wrap");
    nop_in; tick;
  endtask

  task automatic t_interleave;
    ilv_mode = 1;
    rd_p(18, "R10 first");
    step(19, "R10 second");
    step(16, "R10 third");
    step(17, "R10 fourth");
    ilv_mode = 0;
    nop_in; tick;
  endtask

  task automatic t_suspend;
    rd_p(5, "R11 start");
    sel_in; tick;
    chk("R11 hold read", rdata, model[5]);
    // hold write lands at the current address
    sel_in; gw_n = 0; wdata = 18'h2D2D2; tick;
    model[5] = 18'h2D2D2;
    step(6, "R11 next after hold");
    nop_in; tick;
    rd_p(5, "R11 hold write");
    nop_in; tick;
  endtask

  task automatic t_bytes;
    wr_ctl(2, 18'h3FFFF, 1'b1, 1'b0, 2'b10);
    rd_p(2, "R7 byte a only");
    nop_in; tick;
    wr_ctl(4, 18'h00000, 1'b1, 1'b0, 2'b01);
    rd_p(4, "R7 byte b only");
    nop_in; tick;
    wr_ctl(8, 18'h12345, 1'b0, 1'b0, 2'b01);
    rd_p(8, "R6 global overrides strobes");
    nop_in; tick;
  endtask

  task automatic t_read_decode;
    sel_in; adsc_n = 0; addr_i = 6'd11; gw_n = 1; bwe_n = 1; bws_n = 2'b00; wdata = 18'h0;
    tick;
    chk("R8 bwe high reads", rdata, model[11]);
    sel_in; adsc_n = 0; addr_i = 6'd12; gw_n = 1; bwe_n = 0; bws_n = 2'b11; wdata = 18'h0;
    tick;
    chk("R8 no strobe reads", rdata, model[12]);
    nop_in; tick;
  endtask

  task automatic t_padsp_read;
    sel_in; adsp_n = 0; addr_i = 6'd3; gw_n = 0; wdata = 18'h3FFFF;
    tick;
    chk("R14 valid", {17'd0, rvalid}, 18'd1);
    chk("R14 old data", rdata, model[3]);
    nop_in; tick;
    rd_p(3, "R14 unchanged");
    nop_in; tick;
  endtask

  task automatic t_cs1_block;
    rd_p(12, "R3 start");
    sel_in; cs1_n = 1; adsp_n = 0; adv_n = 0; addr_i = 6'd30;
    tick;
    chk("R3 blocked strobe steps", rdata, model[13]);
    nop_in; tick;
  endtask

  task automatic t_deselect;
    rd_p(0, "R4 start");
    sel_in; adsp_n = 0; cs2 = 0; tick;
    chk("R4 deselect clears", {17'd0, rvalid}, 18'd0);
    sel_in; adv_n = 0; gw_n = 0; wdata = 18'h15555; tick;
    chk("R4 step ignored", {17'd0, rvalid}, 18'd0);
    nop_in; tick;
    rd_p(1, "R4 no stray write");
    nop_in; tick;
  endtask

  task automatic t_oe;
    rd_p(14, "R12 read");
    oe_n = 1; #1;
    chk("R12 oe high gates", {17'd0, out_en}, 18'd0);
    chk("R12 zero data", rdata, 18'd0);
    oe_n = 0; #1;
    chk("R12 oe low drives", rdata, model[14]);
    nop_in; tick;
  endtask

  task automatic t_sleep;
    rd_p(20, "R13 start");
    sleep = 1; tick;
    chk("R13 asleep", {17'd0, rvalid}, 18'd0);
    sel_in; adsc_n = 0; addr_i = 6'd20; gw_n = 0; wdata = 18'h0F0F0; tick;
    sleep = 0; sel_in; adv_n = 0;
    tick;
    chk("R13 wake edge 1", {17'd0, rvalid}, 18'd0);
    tick;
    chk("R13 wake edge 2", {17'd0, rvalid}, 18'd0);
    tick;
    chk("R13 resumes", {17'd0, rvalid}, 18'd1);
    chk("R13 burst kept", rdata, model[21]);
    nop_in; tick;
    rd_p(20, "R13 memory kept");
    nop_in; tick;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    nop_in;
    repeat (3) tick;
    rst = 0;
    t_reset;
    tick;
    t_fill;
    t_linear;
    t_interleave;
    t_suspend;
    t_bytes;
    t_read_decode;
    t_padsp_read;
    t_cs1_block;
    t_deselect;
    t_oe;
    t_sleep;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule